// File: doc/BRIEF.md
# Two-Wire Serial Debug Target

This block is the target end of a debug link made of one clock and one shared, bidirectional data line. The host sends framed transactions on the line: writes of an instruction word, writes of a data word, and reads of a data word. The target samples every host bit on the rising clock edge. It decodes a short header, then shifts the payload in or out least significant bit first. Every payload is closed by an odd-parity bit.

On the register side, the block presents the last accepted instruction and the last accepted write data, each with a one-cycle update strobe. A capture strobe asks the register bank for read data, which the block then serializes back onto the line. The line itself is split into an input, an output and an output enable. The enable is raised only while the target owns the line, and a pad or a tri-state stage at chip level merges the three.

A write whose parity bit disagrees is thrown away and raises a sticky error flag. A header outside the defined set is ignored. An asynchronous active-low reset returns the block to idle at any point in a frame.

Top module: `sdbg_slave`

## Requirements
- R1: While dbg_rst_n is low, taking effect without a clock edge, sd_oe, ins_upd, dat_upd, rd_cap and par_err are 0, and reg_ins and reg_wdata are all zeros.
- R2: While the line is high the target idles. A frame opens with a 0 sampled on a rising edge. Three header bits follow in this order: direction (0 write, 1 read), select bit A, select bit B. A=0,B=1 addresses the instruction register and A=1,B=1 the data register. One turnaround bit follows, and its value is not checked.
- R3: On an instruction write, IR_W payload bits arrive least significant bit first, followed by the parity bit. If the parity is valid, reg_ins takes the payload and ins_upd is high for exactly the one cycle after the edge that sampled the parity bit.
- R4: On a data write, DATA_W payload bits arrive least significant bit first, followed by the parity bit. If the parity is valid, reg_wdata takes the payload and dat_upd is high for exactly the one cycle after the edge that sampled the parity bit.
- R5: The parity bit equals 1 XOR every payload bit. On a write whose parity bit differs, neither strobe is raised, reg_ins and reg_wdata keep their values, and par_err becomes 1 and stays 1 until reset.
- R6: On a read of the data register, the cycle after the turnaround is a sync cycle: rd_cap is high and sd_oe is low. reg_rdata is taken at the end of that cycle. The target then drives DATA_W bits least significant bit first, followed by their parity bit computed as in R5. sd_oe is high for exactly those DATA_W+1 cycles and low in the cycle after them.
- R7: Every other header, including a read that addresses the instruction register, causes no strobe and no drive. The target then ignores 0 bits until it samples a 1, and only after that does it accept a new start bit.
- R8: A reset asserted in the middle of a frame abandons that frame. The next complete frame after reset is decoded normally.
- R9: sd_oe is never high outside the R6 window, in particular never during a write. rd_cap is never high in the same cycle as an update strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dbg_clk | input | 1 | Link clock; host bits are sampled on its rising edge |
| dbg_rst_n | input | 1 | Asynchronous active-low reset |
| sd_i | input | 1 | Value seen on the shared data line |
| sd_o | output | 1 | Value the target drives on the line |
| sd_oe | output | 1 | High while the target drives the line |
| reg_rdata | input | DATA_W | Read data from the register bank |
| rd_cap | output | 1 | One-cycle request for reg_rdata (sync cycle) |
| reg_ins | output | IR_W | Last accepted instruction |
| ins_upd | output | 1 | One-cycle pulse when reg_ins is updated |
| reg_wdata | output | DATA_W | Last accepted write data |
| dat_upd | output | 1 | One-cycle pulse when reg_wdata is updated |
| par_err | output | 1 | Sticky flag for a write with bad parity |

## Verification
The bench builds the block with its defaults: DATA_W=32 and IR_W=8. With these values the instruction payload fills only the top byte of the shift register, which exercises the partial-field extraction variant. The data payload uses the full shift register and the full counter range, so the last-bit compare wraps the counter. These widths also cover payloads whose parity bit comes out 0 as well as all-zero and all-one words. They also make the 33-cycle drive window long enough to show that read data is latched at the sync cycle and not later.

// File: rtl/sdbg_pkg.sv
`timescale 1ns/1ps
package sdbg_pkg;

   // frame progress, one state per sampled bit slot
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RW,
      ST_RS0,
      ST_RS1,
      ST_TRN,
      ST_WDAT,
      ST_WPAR,
      ST_SYNC,
      ST_RDAT,
      ST_RPAR,
      ST_TAIL,
      ST_WAITHI
   } sdbg_st_e;

   // transaction kind resolved from the header
   typedef enum logic [1:0] {
      FK_NONE,
      FK_WR_INS,
      FK_WR_DAT,
      FK_RD_DAT
   } sdbg_kind_e;

   function automatic sdbg_kind_e sdbg_decode(input logic rd, input logic sel_a, input logic sel_b);
      sdbg_kind_e k;
      k = FK_NONE;
      if (sel_b) begin
         if (!rd && !sel_a)     k = FK_WR_INS;
         else if (!rd && sel_a) k = FK_WR_DAT;
         else if (rd && sel_a)  k = FK_RD_DAT;
      end
      return k;
   endfunction

endpackage

// File: rtl/sdbg_frame_fsm.sv
`timescale 1ns/1ps
module sdbg_frame_fsm
   import sdbg_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IR_W   = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       line_in,
   output sdbg_st_e   st_o,
   output sdbg_kind_e kind_o
);

   localparam int CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST_DR = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] LAST_IR = CNT_W'(IR_W - 1);

   sdbg_st_e         st_q;
   sdbg_kind_e       kind_q;
   sdbg_kind_e       hdr_kind;
   logic             rd_q;
   logic             sel_a_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_w;

   always_comb begin
      hdr_kind = sdbg_decode(rd_q, sel_a_q, line_in);
      last_w   = (kind_q == FK_WR_INS) ? LAST_IR : LAST_DR;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         kind_q  <= FK_NONE;
         rd_q    <= 1'b0;
         sel_a_q <= 1'b0;
         cnt_q   <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE:   if (!line_in) st_q <= ST_RW;
            ST_RW: begin
               rd_q <= line_in;
               st_q <= ST_RS0;
            end
            ST_RS0: begin
               sel_a_q <= line_in;
               st_q    <= ST_RS1;
            end
            ST_RS1: begin
               kind_q <= hdr_kind;
               st_q   <= (hdr_kind == FK_NONE) ? ST_WAITHI : ST_TRN;
            end
            ST_TRN: begin
               cnt_q <= '0;
               st_q  <= (kind_q == FK_RD_DAT) ? ST_SYNC : ST_WDAT;
            end
            ST_WDAT: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == last_w) st_q <= ST_WPAR;
            end
            ST_WPAR:   st_q <= ST_TAIL;
            ST_SYNC: begin
               cnt_q <= '0;
               st_q  <= ST_RDAT;
            end
            ST_RDAT: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == LAST_DR) st_q <= ST_RPAR;
            end
            ST_RPAR:   st_q <= ST_TAIL;
            ST_TAIL:   st_q <= ST_IDLE;
            ST_WAITHI: if (line_in) st_q <= ST_IDLE;
            default:   st_q <= ST_IDLE;
         endcase
      end
   end

   assign st_o   = st_q;
   assign kind_o = kind_q;

endmodule

// File: rtl/sdbg_shift_par.sv
`timescale 1ns/1ps
module sdbg_shift_par
   import sdbg_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_in,
   input  sdbg_st_e          st_i,
   input  logic [DATA_W-1:0] load_i,
   output logic [DATA_W-1:0] shreg_o,
   output logic              par_o
);

   logic [DATA_W-1:0] sh_q;
   logic              par_q;

   // one register serves both directions: fill from the top on writes,
   // drain from bit 0 on reads; parity runs alongside in both cases
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         par_q <= 1'b1;
      end else begin
         unique case (st_i)
            ST_TRN:  par_q <= 1'b1;
            ST_WDAT: begin
               sh_q  <= {line_in, sh_q[DATA_W-1:1]};
               par_q <= par_q ^ line_in;
            end
            ST_SYNC: begin
               sh_q  <= load_i;
               par_q <= 1'b1;
            end
            ST_RDAT: begin
               sh_q  <= {1'b0, sh_q[DATA_W-1:1]};
               par_q <= par_q ^ sh_q[0];
            end
            default: ;
         endcase
      end
   end

   assign shreg_o = sh_q;
   assign par_o   = par_q;

endmodule

// File: rtl/sdbg_commit.sv
`timescale 1ns/1ps
module sdbg_commit
   import sdbg_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IR_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_in,
   input  sdbg_st_e          st_i,
   input  sdbg_kind_e        kind_i,
   input  logic [DATA_W-1:0] shreg_i,
   input  logic              par_i,
   output logic [IR_W-1:0]   ins_o,
   output logic              ins_upd_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic              dat_upd_o,
   output logic              perr_o
);

   logic [IR_W-1:0] ins_field;

   // a short instruction lands in the top IR_W bits of the shift register
   generate
      if (IR_W == DATA_W) begin : g_ins_full
         assign ins_field = shreg_i;
      end else begin : g_ins_part
         assign ins_field = shreg_i[DATA_W-1 -: IR_W];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ins_o     <= '0;
         wdata_o   <= '0;
         ins_upd_o <= 1'b0;
         dat_upd_o <= 1'b0;
         perr_o    <= 1'b0;
      end else begin
         ins_upd_o <= 1'b0;
         dat_upd_o <= 1'b0;
         if (st_i == ST_WPAR) begin
            if (line_in == par_i) begin
               if (kind_i == FK_WR_INS) begin
                  ins_o     <= ins_field;
                  ins_upd_o <= 1'b1;
               end else if (kind_i == FK_WR_DAT) begin
                  wdata_o   <= shreg_i;
                  dat_upd_o <= 1'b1;
               end
            end else begin
               perr_o <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/sdbg_slave.sv
`timescale 1ns/1ps
module sdbg_slave
   import sdbg_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IR_W   = 8
) (
   input  logic              dbg_clk,
   input  logic              dbg_rst_n,
   input  logic              sd_i,
   output logic              sd_o,
   output logic              sd_oe,
   input  logic [DATA_W-1:0] reg_rdata,
   output logic              rd_cap,
   output logic [IR_W-1:0]   reg_ins,
   output logic              ins_upd,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              dat_upd,
   output logic              par_err
);

   generate
      if (DATA_W < 2) begin : g_bad_data_w
         $error("sdbg_slave: DATA_W must be at least 2");
      end
      if (IR_W < 1 || IR_W > DATA_W) begin : g_bad_ir_w
         $error("sdbg_slave: IR_W must lie in 1..DATA_W");
      end
   endgenerate

   sdbg_st_e          st;
   sdbg_kind_e        kind;
   logic [DATA_W-1:0] shreg;
   logic              par;

   sdbg_frame_fsm #(.DATA_W(DATA_W), .IR_W(IR_W)) u_fsm (
      .clk     (dbg_clk),
      .rst_n   (dbg_rst_n),
      .line_in (sd_i),
      .st_o    (st),
      .kind_o  (kind)
   );

   sdbg_shift_par #(.DATA_W(DATA_W)) u_shift (
      .clk     (dbg_clk),
      .rst_n   (dbg_rst_n),
      .line_in (sd_i),
      .st_i    (st),
      .load_i  (reg_rdata),
      .shreg_o (shreg),
      .par_o   (par)
   );

   sdbg_commit #(.DATA_W(DATA_W), .IR_W(IR_W)) u_commit (
      .clk       (dbg_clk),
      .rst_n     (dbg_rst_n),
      .line_in   (sd_i),
      .st_i      (st),
      .kind_i    (kind),
      .shreg_i   (shreg),
      .par_i     (par),
      .ins_o     (reg_ins),
      .ins_upd_o (ins_upd),
      .wdata_o   (reg_wdata),
      .dat_upd_o (dat_upd),
      .perr_o    (par_err)
   );

   // line ownership follows the frame state directly
   always_comb begin
      sd_oe  = (st == ST_RDAT) || (st == ST_RPAR);
      rd_cap = (st == ST_SYNC);
      if (!sd_oe)              sd_o = 1'b1;
      else if (st == ST_RPAR)  sd_o = par;
      else                     sd_o = shreg[0];
   end

endmodule

// File: rtl/sdbg_slave_chk.sv
`timescale 1ns/1ps
module sdbg_slave_chk #(
   parameter int DATA_W = 32,
   parameter int IR_W   = 8
) (
   input logic              dbg_clk,
   input logic              dbg_rst_n,
   input logic              sd_oe,
   input logic              rd_cap,
   input logic [IR_W-1:0]   reg_ins,
   input logic              ins_upd,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              dat_upd,
   input logic              par_err
);

   localparam int RUN_W = $clog2(DATA_W + 2);

   logic [RUN_W-1:0] oe_run;

   always_ff @(posedge dbg_clk or negedge dbg_rst_n) begin
      if (!dbg_rst_n)  oe_run <= '0;
      else if (sd_oe)  oe_run <= oe_run + 1'b1;
      else             oe_run <= '0;
   end

   // R3: instruction output moves only together with its strobe
   p_ins_hold_r3: assert property (@(posedge dbg_clk) disable iff (!dbg_rst_n)
      !ins_upd |-> $stable(reg_ins));
   p_ins_pulse_r3: assert property (@(posedge dbg_clk) disable iff (!dbg_rst_n)
      ins_upd |=> !ins_upd);
   // R4: write data moves only together with its strobe
   p_dat_hold_r4: assert property (@(posedge dbg_clk) disable iff (!dbg_rst_n)
      !dat_upd |-> $stable(reg_wdata));
   p_dat_pulse_r4: assert property (@(posedge dbg_clk) disable iff (!dbg_rst_n)
      dat_upd |=> !dat_upd);
   // R5: error flag is sticky
   p_err_sticky_r5: assert property (@(posedge dbg_clk) disable iff (!dbg_rst_n)
      par_err |=> par_err);
   // R6: capture precedes driving, drive window has fixed length
   p_cap_then_drive_r6: assert property (@(posedge dbg_clk) disable iff (!dbg_rst_n)
      rd_cap |=> sd_oe);
   p_drive_after_cap_r6: assert property (@(posedge dbg_clk) disable iff (!dbg_rst_n)
      $rose(sd_oe) |-> $past(rd_cap));
   p_drive_len_r6: assert property (@(posedge dbg_clk) disable iff (!dbg_rst_n)
      $fell(sd_oe) |-> (oe_run == RUN_W'(DATA_W + 1)));
   // R9: strobes and drive never coincide
   p_excl_r9: assert property (@(posedge dbg_clk) disable iff (!dbg_rst_n)
      $onehot0({ins_upd, dat_upd, rd_cap, sd_oe}));

endmodule

bind sdbg_slave sdbg_slave_chk #(.DATA_W(DATA_W), .IR_W(IR_W)) u_chk (
   .dbg_clk   (dbg_clk),
   .dbg_rst_n (dbg_rst_n),
   .sd_oe     (sd_oe),
   .rd_cap    (rd_cap),
   .reg_ins   (reg_ins),
   .ins_upd   (ins_upd),
   .reg_wdata (reg_wdata),
   .dat_upd   (dat_upd),
   .par_err   (par_err)
);

// File: tb/tb_sdbg_slave.sv
`timescale 1ns/1ps
module tb_sdbg_slave;

   localparam int DW = 32;
   localparam int IW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_drv = 1'b1;
   logic          host_bit = 1'b1;
   logic [DW-1:0] rdata = '0;
   logic          sd_i;
   logic          sd_o, sd_oe, rd_cap, ins_upd, dat_upd, par_err;
   logic [IW-1:0] reg_ins;
   logic [DW-1:0] reg_wdata;

   int checks = 0, fails = 0, cyc = 0;
   int n_ins = 0, n_dat = 0, n_cap = 0, n_oe = 0, n_clash = 0;

   // pulled high when nobody drives
   assign sd_i = sd_oe ? sd_o : (host_drv ? host_bit : 1'b1);

   sdbg_slave #(.DATA_W(DW), .IR_W(IW)) dut (
      .dbg_clk(clk), .dbg_rst_n(rst_n), .sd_i(sd_i), .sd_o(sd_o), .sd_oe(sd_oe),
      .reg_rdata(rdata), .rd_cap(rd_cap), .reg_ins(reg_ins), .ins_upd(ins_upd),
      .reg_wdata(reg_wdata), .dat_upd(dat_upd), .par_err(par_err)
   );

   always #2.5 clk = ~clk;

   always @(posedge clk) begin
      cyc++;
      if (ins_upd) n_ins++;
      if (dat_upd) n_dat++;
      if (rd_cap)  n_cap++;
      if (sd_oe)   n_oe++;
      if (sd_oe && host_drv) n_clash++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog (all requirements) actual=%0d expected<=150000 cycles", cyc);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic opar(input logic [DW-1:0] v, input int len);
      logic p = 1'b1;
      for (int i = 0; i < len; i++) p ^= v[i];
      return p;
   endfunction

   task automatic send_bit(input logic b);
      @(negedge clk);
      host_drv = 1'b1;
      host_bit = b;
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk("R1", "outputs in reset", {sd_oe, ins_upd, dat_upd, rd_cap, par_err}, 0);
      chk("R1", "regs in reset", {reg_ins, reg_wdata}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1", "outputs after reset", {sd_oe, ins_upd, dat_upd, rd_cap, par_err}, 0);
   endtask

   task automatic t_write(input string req, input bit ins, input logic [DW-1:0] v, input bit bad);
      int            len = ins ? IW : DW;
      logic [IW-1:0] ins0 = reg_ins;
      logic [DW-1:0] wd0 = reg_wdata;
      int            ni0 = n_ins, nd0 = n_dat;
      send_bit(1'b0); send_bit(1'b0); send_bit(ins ? 1'b0 : 1'b1); send_bit(1'b1); send_bit(1'b1);
      for (int i = 0; i < len; i++) send_bit(v[i]);
      send_bit(opar(v, len) ^ bad);
      @(negedge clk);
      if (bad) begin
         chk("R5", "no strobe on bad parity", {ins_upd, dat_upd}, 0);
         chk("R5", "error flag set", par_err, 1);
      end else if (ins) begin
         chk(req, "ins strobe", {ins_upd, dat_upd}, 2'b10);
         chk(req, "ins value", reg_ins, v[IW-1:0]);
         chk(req, "wdata untouched", reg_wdata, wd0);
      end else begin
         chk(req, "dat strobe", {ins_upd, dat_upd}, 2'b01);
         chk(req, "dat value", reg_wdata, v);
         chk(req, "ins untouched", reg_ins, ins0);
      end
      host_bit = 1'b1;
      @(negedge clk);
      chk(req, "strobe lasts one cycle", {ins_upd, dat_upd}, 0);
      repeat (2) @(negedge clk);
      if (bad) begin
         chk("R5", "ins kept", reg_ins, ins0);
         chk("R5", "wdata kept", reg_wdata, wd0);
         chk("R5", "no strobe counted", (n_ins - ni0) + (n_dat - nd0), 0);
      end else begin
         chk(req, "one strobe counted", (n_ins - ni0) + (n_dat - nd0), 1);
      end
   endtask

   task automatic t_read(input logic [DW-1:0] v);
      logic [DW-1:0] got = '0;
      int            nc0 = n_cap, oe_miss = 0;
      rdata = v;
      send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
      @(negedge clk);
      host_drv = 1'b0;
      chk("R6", "sync cycle capture/oe", {rd_cap, sd_oe}, 2'b10);
      @(negedge clk);
      rdata = ~v;  // data after the sync cycle must not be used
      for (int i = 0; i < DW; i++) begin
         if (i > 0) @(negedge clk);
         if (!sd_oe) oe_miss++;
         got[i] = sd_o;
      end
      @(negedge clk);
      chk("R6", "oe on parity bit", sd_oe, 1);
      chk("R6", "read parity", sd_o, opar(v, DW));
      @(negedge clk);
      chk("R6", "line released after parity", sd_oe, 0);
      host_drv = 1'b1;
      host_bit = 1'b1;
      chk("R6", "read data", got, v);
      chk("R6", "oe through data bits", oe_miss, 0);
      chk("R6", "one capture", n_cap - nc0, 1);
      rdata = v;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_bad_hdr(input bit rd, input bit sa, input bit sb, input bit low_tail);
      logic [IW-1:0] ins0 = reg_ins;
      logic [DW-1:0] wd0 = reg_wdata;
      int            s0 = n_ins + n_dat + n_cap + n_oe;
      send_bit(1'b0); send_bit(rd); send_bit(sa); send_bit(sb);
      if (low_tail) repeat (3) send_bit(1'b0);
      repeat (40) send_bit(1'b1);
      @(negedge clk);
      chk("R7", "no strobe or drive", n_ins + n_dat + n_cap + n_oe - s0, 0);
      chk("R7", "regs unchanged", {reg_ins, reg_wdata}, {ins0, wd0});
   endtask

   task automatic t_reset_mid();
      send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
      for (int i = 0; i < 10; i++) send_bit(i[0]);
      @(negedge clk);
      host_bit = 1'b1;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R8", "cleared by mid-frame reset", {reg_ins, reg_wdata, par_err, sd_oe}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_write("R8", 1'b0, 32'h0BAD_F00D, 1'b0);
   endtask

   initial begin
      t_reset();
      t_write("R2/R3", 1'b1, 32'h0000_00A5, 1'b0);
      t_write("R3", 1'b1, 32'h0000_0001, 1'b0);
      t_write("R2/R4", 1'b0, 32'h1234_5678, 1'b0);
      t_write("R4", 1'b0, 32'h0000_0000, 1'b0);
      t_write("R4", 1'b0, 32'hFFFF_FFFF, 1'b0);
      t_read(32'hDEAD_BEEF);
      t_read(32'h0000_0001);
      t_read(32'h0000_0000);
      t_bad_hdr(1'b0, 1'b1, 1'b0, 1'b0);
      t_bad_hdr(1'b1, 1'b0, 1'b1, 1'b0);
      t_bad_hdr(1'b0, 1'b0, 1'b0, 1'b1);
      t_write("R7", 1'b1, 32'h0000_003C, 1'b0);
      t_write("R5", 1'b0, 32'hCAFE_F00D, 1'b1);
      t_write("R5", 1'b1, 32'h0000_005A, 1'b1);
      t_write("R5", 1'b1, 32'h0000_005A, 1'b0);
      chk("R5", "error flag sticky", par_err, 1);
      t_reset_mid();
      chk("R9", "no drive while host drives", n_clash, 0);
      chk("R9", "drive cycles total", n_oe, 3 * (DW + 1));
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule